// File: doc/BRIEF.md
# Prescaled Reference Counter Pair with Match Pulses

This block holds a configurable number of independent 32-bit counters, two by default, that advance on a slow reference tick. The tick is a single-cycle pulse in the system clock domain at the 32.768 kHz reference rate. Each counter has a 16-bit prescaler. The prescaler can be bypassed so that the counter steps on every tick. Each counter also has three match registers, and each match register drives its own single-cycle interrupt pulse.

Software uses a simple write port and a combinational read port. A write does not take effect at once. It first goes into a holding register. A settle tracker for that register then raises a pending flag. The value moves into the counting logic on the second reference tick after the write, and the flag clears at that point. One shared control register sets the enable and the prescaler bypass of every counter, and a read of it returns all pending flags.

Top module: `ptc_top`

## Requirements
- R1: After reset, every count, trim, match, enable and bypass value reads 0, the control register reads 0, and no match pulse is raised.
- R2: Address map. Counter c is based at c*8. Its offsets are: +0 trim (bits 15:0 are stored, the read is zero-extended), +1 count load, +2, +3 and +4 match 0, 1 and 2, and +5 live count (read only, so writes to it are ignored). The control register is at address 15. Any other address reads 0. Each writable register reads back the last value written to it.
- R3: A write to control sets enable of counter c from bit 2c and bypass of counter c from bit 2c+1. A read of control returns those bits in the same places. It also returns the pending flag of counter c, register k, at bit 8+8c+k, where k is 0 for count, 1 for trim, 2..4 for matches 0..2 and 5 for enable/bypass.
- R4: The pending flag of a register is set in the cycle after a write to it. It clears on the second reference tick after that write. A new write to the same register restarts the two-tick wait.
- R5: A written value takes effect on the reference tick where its pending flag clears. That tick still counts with the old settings. A count load replaces the count on that tick instead of incrementing it.
- R6: A counter whose enable is 0 holds its count across reference ticks.
- R7: With bypass 0 and trim N, an enabled counter steps once every N+1 reference ticks. Trim 0 steps it on every tick. Applying a new trim restarts the prescale phase.
- R8: With bypass 1, an enabled counter steps on every reference tick whatever its trim holds.
- R9: Match pulse bit 3c+m is high for exactly one cycle. It rises the cycle after a reference tick on which counter c increments to the value of its match register m.
- R10: A count load never raises a match pulse, even if the loaded value equals a match value. The count wraps from 0xFFFFFFFF to 0.
- R11: Counters are independent: ticks, writes and matches of one counter leave the count and pulses of another unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse at the reference rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Combinational read data |
| match_irq | output | N_CH*3 | Match pulses, bit 3c+m |

## Verification
The counting path is tried with three settings: trim 2, trim 0, and bypass with a non-zero trim. Together they show whether the N+1 ratio is applied, whether a zero trim degenerates cleanly, and whether bypass really ignores the divider. The delayed-commit path is tried in three ways. A count load is made into a running counter and its readback is compared one and two ticks later. A register is rewritten while its write is still pending. An enable is cleared, which shows that the commit tick still runs with the old settings. Match pulses are tried in two ways: by counting up through a match value, and by loading that same value directly. The second case tells a compare on the next value apart from a compare on the current value.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int CNT_W        = 32;
  localparam int TRIM_W       = 16;
  localparam int N_MATCH      = 3;
  localparam int N_SLOT       = 6;
  localparam int SETTLE_TICKS = 2;
  localparam int STAT_BASE    = 8;
  localparam int STAT_STRIDE  = 8;

  // slot numbers double as status bit offsets
  localparam logic [2:0] SLOT_COUNT = 3'd0;
  localparam logic [2:0] SLOT_TRIM  = 3'd1;
  localparam logic [2:0] SLOT_M0    = 3'd2;
  localparam logic [2:0] SLOT_EN    = 3'd5;

  function automatic logic prescale_wrap(input logic byp,
                                         input logic [TRIM_W-1:0] phase,
                                         input logic [TRIM_W-1:0] trim);
    return byp || (phase == trim);
  endfunction

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  // address offset inside a counter window -> register slot (7 = none)
  function automatic logic [2:0] offset_slot(input logic [2:0] off);
    case (off)
      3'd0:    return SLOT_TRIM;
      3'd1:    return SLOT_COUNT;
      3'd2,
      3'd3,
      3'd4:    return off;
      default: return 3'd7;
    endcase
  endfunction

  function automatic int stat_bit(input int ch, input int slot);
    return STAT_BASE + STAT_STRIDE * ch + slot;
  endfunction
endpackage

// File: rtl/ptc_pend.sv
module ptc_pend #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic wr_hit,
  output logic pending,
  output logic apply
);
  localparam int LW = $clog2(SETTLE + 1);

  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        left <= '0;
    else if (wr_hit)                   left <= LW'(SETTLE);
    else if (ref_tick && left != '0)   left <= left - 1'b1;
  end

  assign pending = (left != '0);
  assign apply   = ref_tick && !wr_hit && (left == LW'(1));
endmodule

// File: rtl/ptc_chan.sv
module ptc_chan
  import ptc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_tick,
  input  logic [N_SLOT-1:0]        wr_hit,
  input  logic [CNT_W-1:0]         wr_data,
  input  logic                     en_in,
  input  logic                     byp_in,
  output logic [CNT_W-1:0]         count,
  output logic [CNT_W-1:0]         sh_count,
  output logic [TRIM_W-1:0]        sh_trim,
  output logic [N_MATCH*CNT_W-1:0] sh_match,
  output logic                     sh_en,
  output logic                     sh_byp,
  output logic [N_SLOT-1:0]        pend,
  output logic [N_SLOT-1:0]        apply,
  output logic                     inc,
  output logic [N_MATCH-1:0]       irq
);
  logic [TRIM_W-1:0]        act_trim;
  logic [N_MATCH*CNT_W-1:0] act_match;
  logic                     act_en, act_byp;
  logic [TRIM_W-1:0]        phase;
  logic                     wrap;
  logic [CNT_W-1:0]         cnt_nx;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_pend
    ptc_pend #(.SETTLE(SETTLE_TICKS)) u_pend (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .wr_hit(wr_hit[s]), .pending(pend[s]), .apply(apply[s])
    );
  end

  // holding registers, written straight from the bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_count <= '0; sh_trim <= '0; sh_match <= '0; sh_en <= 1'b0; sh_byp <= 1'b0;
    end else begin
      if (wr_hit[SLOT_COUNT]) sh_count <= wr_data;
      if (wr_hit[SLOT_TRIM])  sh_trim  <= wr_data[TRIM_W-1:0];
      for (int m = 0; m < N_MATCH; m++)
        if (wr_hit[int'(SLOT_M0) + m]) sh_match[m*CNT_W +: CNT_W] <= wr_data;
      if (wr_hit[SLOT_EN]) begin
        sh_en  <= en_in;
        sh_byp <= byp_in;
      end
    end
  end

  // values in use by the counting logic
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_trim <= '0; act_match <= '0; act_en <= 1'b0; act_byp <= 1'b0;
    end else begin
      if (apply[SLOT_TRIM]) act_trim <= sh_trim;
      for (int m = 0; m < N_MATCH; m++)
        if (apply[int'(SLOT_M0) + m]) act_match[m*CNT_W +: CNT_W] <= sh_match[m*CNT_W +: CNT_W];
      if (apply[SLOT_EN]) begin
        act_en  <= sh_en;
        act_byp <= sh_byp;
      end
    end
  end

  assign wrap   = prescale_wrap(act_byp, phase, act_trim);
  assign inc    = ref_tick && act_en && wrap;
  assign cnt_nx = count_step(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      phase <= '0;
      irq   <= '0;
    end else begin
      if (apply[SLOT_COUNT]) count <= sh_count;
      else if (inc)          count <= cnt_nx;

      if (apply[SLOT_TRIM])          phase <= '0;
      else if (ref_tick && act_en)   phase <= wrap ? '0 : phase + 1'b1;

      for (int m = 0; m < N_MATCH; m++)
        irq[m] <= inc && !apply[SLOT_COUNT] && (cnt_nx == act_match[m*CNT_W +: CNT_W]);
    end
  end
endmodule

// File: rtl/ptc_top.sv
module ptc_top
  import ptc_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_tick,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [CNT_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [CNT_W-1:0]        rd_data,
  output logic [N_CH*N_MATCH-1:0] match_irq
);
  localparam int CH_W = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

  logic [N_CH*CNT_W-1:0]  count_w;
  logic [N_CH-1:0]        inc_w;
  logic [N_CH*N_SLOT-1:0] pend_w;
  logic [N_CH-1:0]        capply_w;

  logic [CNT_W-1:0]         sh_count_a [N_CH];
  logic [TRIM_W-1:0]        sh_trim_a  [N_CH];
  logic [N_MATCH*CNT_W-1:0] sh_match_a [N_CH];
  logic [N_CH-1:0]          sh_en_a, sh_byp_a;

  logic [2:0]      wr_off, rd_off, wr_slot;
  logic [CH_W-1:0] wr_ch, rd_ch;
  logic            wr_ctrl;

  assign wr_off  = wr_addr[2:0];
  assign wr_ch   = wr_addr[ADDR_W-1:3];
  assign rd_off  = rd_addr[2:0];
  assign rd_ch   = rd_addr[ADDR_W-1:3];
  assign wr_slot = offset_slot(wr_off);
  assign wr_ctrl = wr_en && (wr_addr == CTRL_ADDR);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [N_SLOT-1:0] hit;
    logic [N_SLOT-1:0] app;

    always_comb begin
      for (int s = 0; s < N_SLOT; s++)
        hit[s] = wr_en && (wr_ch == CH_W'(c)) && (wr_slot == 3'(s));
      if (wr_ctrl) hit[SLOT_EN] = 1'b1;
    end

    ptc_chan u_chan (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .wr_hit(hit), .wr_data(wr_data),
      .en_in(wr_data[2*c]), .byp_in(wr_data[2*c+1]),
      .count(count_w[c*CNT_W +: CNT_W]),
      .sh_count(sh_count_a[c]), .sh_trim(sh_trim_a[c]), .sh_match(sh_match_a[c]),
      .sh_en(sh_en_a[c]), .sh_byp(sh_byp_a[c]),
      .pend(pend_w[c*N_SLOT +: N_SLOT]), .apply(app),
      .inc(inc_w[c]), .irq(match_irq[c*N_MATCH +: N_MATCH])
    );
    assign capply_w[c] = app[SLOT_COUNT];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_ADDR) begin
      for (int c = 0; c < N_CH; c++) begin
        rd_data[2*c]   = sh_en_a[c];
        rd_data[2*c+1] = sh_byp_a[c];
        for (int s = 0; s < N_SLOT; s++)
          rd_data[stat_bit(c, s)] = pend_w[c*N_SLOT + s];
      end
    end else begin
      for (int c = 0; c < N_CH; c++) begin
        if (rd_ch == CH_W'(c)) begin
          case (rd_off)
            3'd0:          rd_data = CNT_W'(sh_trim_a[c]);
            3'd1:          rd_data = sh_count_a[c];
            3'd2, 3'd3,
            3'd4:          rd_data = sh_match_a[c][(int'(rd_off) - 2)*CNT_W +: CNT_W];
            3'd5:          rd_data = count_w[c*CNT_W +: CNT_W];
            default:       rd_data = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
  import ptc_pkg::*;
#(
  parameter int N_CH = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ref_tick,
  input logic [N_CH*N_MATCH-1:0] match_irq,
  input logic [N_CH*CNT_W-1:0]   count_w,
  input logic [N_CH-1:0]         inc_w,
  input logic [N_CH*N_SLOT-1:0]  pend_w,
  input logic [N_CH-1:0]         capply_w
);
  for (genvar c = 0; c < N_CH; c++) begin : g_c
    // R7 / R8: an increment event advances the count by exactly one
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inc_w[c] && !capply_w[c] |=> count_w[c*CNT_W +: CNT_W] == $past(count_w[c*CNT_W +: CNT_W]) + 1'b1);

    // R5 / R6: without a reference tick the count cannot move
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |=> $stable(count_w[c*CNT_W +: CNT_W]));

    for (genvar s = 0; s < N_SLOT; s++) begin : g_s
      // R4: a pending flag only clears on a reference tick
      p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_w[c*N_SLOT + s]) |-> $past(ref_tick));
    end

    for (genvar m = 0; m < N_MATCH; m++) begin : g_m
      // R9 / R10: a pulse needs a preceding increment that was not a load
      p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq[c*N_MATCH + m] |-> $past(inc_w[c] && !capply_w[c]));
      // R9: pulses last a single cycle
      p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq[c*N_MATCH + m] |=> !match_irq[c*N_MATCH + m]);
    end
  end
endmodule

bind ptc_top ptc_checker #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .match_irq(match_irq),
  .count_w(count_w), .inc_w(inc_w), .pend_w(pend_w), .capply_w(capply_w)
);

// File: tb/ptc_top_tb_top.sv
`timescale 1ns/1ps
module ptc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [5:0]  match_irq;

  int total = 0;
  int fails = 0;
  int irq_cnt [6];
  int irq_double = 0;
  logic [5:0] irq_prev = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ptc_top dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .match_irq(match_irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < 6; b++) begin
        if (match_irq[b]) irq_cnt[b]++;
        if (match_irq[b] && irq_prev[b]) irq_double++;
      end
      irq_prev <= match_irq;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_tick = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int b = 0; b < 6; b++) irq_cnt[b] = 0;
    irq_double = 0;
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset_r1();
    logic [31:0] v;
    do_reset();
    bus_rd(4'd15, v); check_eq("R1 control", v, 32'h0);
    bus_rd(4'd5, v);  check_eq("R1 count0", v, 32'h0);
    bus_rd(4'd13, v); check_eq("R1 count1", v, 32'h0);
    bus_rd(4'd0, v);  check_eq("R1 trim0", v, 32'h0);
    check_eq("R1 irq", {26'h0, match_irq}, 32'h0);
  endtask

  task automatic t_map_r2_r3();
    logic [31:0] v;
    do_reset();
    bus_wr(4'd0, 32'h0001_2345);
    bus_rd(4'd0, v); check_eq("R2 trim 16-bit readback", v, 32'h0000_2345);
    bus_wr(4'd12, 32'hDEAD_BEEF);
    bus_rd(4'd12, v); check_eq("R2 ch1 match2 readback", v, 32'hDEAD_BEEF);
    bus_rd(4'd6, v); check_eq("R2 unmapped reads zero", v, 32'h0);
    bus_wr(4'd5, 32'd77);
    bus_rd(4'd5, v); check_eq("R2 live count write ignored", v, 32'h0);
    bus_wr(4'd15, 32'h0000_0009);
    bus_rd(4'd15, v); check_eq("R3 control enable/bypass bits", v & 32'hFF, 32'h9);
    check_eq("R3 enable pending bits 13,21", v & 32'h0020_2000, 32'h0020_2000);
  endtask

  task automatic t_pending_r4();
    logic [31:0] v;
    do_reset();
    bus_wr(4'd0, 32'd4);
    bus_rd(4'd15, v); check_eq("R4 trim0 pending after write", v & 32'h200, 32'h200);
    tick(1);
    bus_rd(4'd15, v); check_eq("R4 still pending after one tick", v & 32'h200, 32'h200);
    tick(1);
    bus_rd(4'd15, v); check_eq("R4 cleared after two ticks", v, 32'h0);
    bus_wr(4'd10, 32'd1);
    tick(1);
    bus_wr(4'd10, 32'd2);
    tick(1);
    bus_rd(4'd15, v); check_eq("R4 rewrite restarts wait", v & 32'h0004_0000, 32'h0004_0000);
    tick(1);
    bus_rd(4'd15, v); check_eq("R4 rewrite clears after two ticks", v, 32'h0);
  endtask

  task automatic t_trim_r7();
    logic [31:0] v;
    do_reset();
    bus_wr(4'd0, 32'd2);
    bus_wr(4'd15, 32'h1);
    tick(2);
    bus_rd(4'd5, v); check_eq("R7 commit tick does not count", v, 32'd0);
    tick(3);
    bus_rd(4'd5, v); check_eq("R7 trim 2 -> one step per 3 ticks", v, 32'd1);
    tick(2);
    bus_rd(4'd5, v); check_eq("R7 no step mid-period", v, 32'd1);
    tick(1);
    bus_rd(4'd5, v); check_eq("R7 second step", v, 32'd2);
    do_reset();
    bus_wr(4'd15, 32'h1);
    tick(2);
    tick(4);
    bus_rd(4'd5, v); check_eq("R7 trim 0 steps every tick", v, 32'd4);
  endtask

  task automatic t_bypass_r8_r6();
    logic [31:0] v;
    do_reset();
    bus_wr(4'd0, 32'd7);
    bus_wr(4'd15, 32'h3);
    tick(2);
    tick(3);
    bus_rd(4'd5, v); check_eq("R8 bypass ignores trim", v, 32'd3);
    bus_wr(4'd15, 32'h0);
    tick(2);
    bus_rd(4'd5, v); check_eq("R5 old enable used through commit tick", v, 32'd5);
    tick(4);
    bus_rd(4'd5, v); check_eq("R6 disabled counter holds", v, 32'd5);
  endtask

  task automatic t_load_r5();
    logic [31:0] v;
    do_reset();
    bus_wr(4'd15, 32'h3);
    tick(2);
    bus_wr(4'd1, 32'd100);
    tick(1);
    bus_rd(4'd5, v); check_eq("R5 load not yet applied", v, 32'd1);
    tick(1);
    bus_rd(4'd5, v); check_eq("R5 load replaces count", v, 32'd100);
    tick(1);
    bus_rd(4'd5, v); check_eq("R5 counts on from loaded value", v, 32'd101);
  endtask

  task automatic t_match_r9_r10_r11();
    logic [31:0] v;
    do_reset();
    bus_wr(4'd11, 32'd5);
    bus_wr(4'd9, 32'd3);
    bus_wr(4'd15, 32'hC);
    tick(2);
    bus_rd(4'd13, v); check_eq("R5 ch1 loaded", v, 32'd3);
    tick(1);
    check_eq("R9 no pulse before match", 32'(irq_cnt[4]), 32'd0);
    tick(1);
    check_eq("R9 pulse on bit 4 at match", 32'(irq_cnt[4]), 32'd1);
    tick(3);
    check_eq("R9 exactly one pulse", 32'(irq_cnt[4]), 32'd1);
    check_eq("R9 pulse lasts one cycle", 32'(irq_double), 32'd0);
    check_eq("R9 other match bits quiet",
             32'(irq_cnt[0] + irq_cnt[1] + irq_cnt[2] + irq_cnt[3] + irq_cnt[5]), 32'd0);
    bus_rd(4'd5, v); check_eq("R11 ch0 untouched", v, 32'd0);
    bus_wr(4'd9, 32'd5);
    tick(2);
    bus_rd(4'd13, v); check_eq("R10 load to match value", v, 32'd5);
    check_eq("R10 load raises no pulse", 32'(irq_cnt[4]), 32'd1);
    bus_wr(4'd9, 32'hFFFF_FFFF);
    tick(2);
    tick(1);
    bus_rd(4'd13, v); check_eq("R10 wrap to zero", v, 32'd0);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    t_reset_r1();
    t_map_r2_r3();
    t_pending_r4();
    t_trim_r7();
    t_bypass_r8_r6();
    t_load_r5();
    t_match_r9_r10_r11();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule